// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches two external interrupt inputs and turns each into a request line for an interrupt controller. The inputs reach it already synchronized to the clock. Software selects one of two trigger types for each source. In falling-edge mode, a high-to-low transition on the input latches a pending flag. The acknowledge that takes that source's vector clears the flag again. In low-level mode, the request simply tracks the inverted input and nothing is latched.

A four-bit control nibble holds one type bit and one flag bit per source. Software reads and writes the nibble over a single-cycle register bus. A write replaces all four bits at once, so software can raise or withdraw an interrupt directly. Each source also drives a constant vector address: 0003h for source 0 and 0013h for source 1. The acknowledge input compares against these addresses.

Each source has a two-state machine. `CH_IDLE` means no flag is held and `CH_PENDING` means the flag is held. The transitions are:
- *capture* (`CH_IDLE` to `CH_PENDING`): a falling edge is seen while the source is in edge mode.
- *retire* (`CH_PENDING` to `CH_IDLE`): the source's own vector is acknowledged and no new edge arrives in the same cycle.
- *force*: a register write moves the machine to whichever state the written flag bit names, from either state.

Top module: `eirq_detector`

## Requirements
- R1: After reset the nibble reads 0000 (both sources in level mode, no flags). The previous-sample register of each input starts at 1.
- R2: `reg_rdata` bit 3 is flag 1, bit 2 is type 1, bit 1 is flag 0 and bit 0 is type 0. A `reg_wr` pulse loads all four bits from `reg_wdata` at the next clock edge.
- R3: With type bit = 1 (edge mode), the flag sets at the clock edge where the previous sample is 1 and the current input is 0. The request of that source equals its flag.
- R4: With type bit = 0 (level mode), the request equals the inverted current input in the same cycle, and an input edge does not set the flag.
- R5: An acknowledge (`ack_valid` = 1) with `ack_vector` 0003h clears flag 0 only, and with 0013h clears flag 1 only. Any other vector, or `ack_valid` = 0, changes no flag.
- R6: If a qualifying falling edge coincides with an acknowledge of its own vector, the flag stays set.
- R7: A register write takes precedence over both an edge and an acknowledge in the same cycle.
- R8: `irq_vec` bits 15:0 read 0003h and bits 31:16 read 0013h at all times.
- R9: An input held low after its flag is acknowledged does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 2 | Synchronized interrupt inputs, bit i is source i |
| reg_wr | input | 1 | Control nibble write strobe |
| reg_wdata | input | 4 | Control nibble write data |
| reg_rdata | output | 4 | Control nibble read data |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_vector | input | 16 | Vector address being taken |
| irq_req | output | 2 | Request per source |
| irq_vec | output | 32 | Vector address per source, 16 bits each |

## Verification
The hardest case to reach is a falling edge that lands in the same cycle as an acknowledge of the same source. In that cycle, the capture and retire transitions compete. The bench first raises the flag, then returns the input high for one cycle. It then drops the input and presents the acknowledge in the same clock. An exhaustive sweep over input pairs, acknowledge vectors, write strobes and write data also reaches this case, together with its write-versus-edge variants, many times. A bench model predicts every resulting nibble.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } chan_state_e;

    function automatic int vec_addr(input int base, input int stride, input int idx);
        return base + idx * stride;
    endfunction

endpackage

// File: rtl/eirq_fall_det.sv
`timescale 1ns/1ps
module eirq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= pin;
        end
    end

    always_comb begin
        fall = prev_q & ~pin;
    end

endmodule

// File: rtl/eirq_chan.sv
`timescale 1ns/1ps
module eirq_chan
    import eirq_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] VADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             wr_en,
    input  logic             wr_type,
    input  logic             wr_flag,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vector,
    output logic             type_o,
    output logic             flag_o,
    output logic             req_o
);

    chan_state_e state_q, state_d;
    logic        type_q;
    logic        fall;
    logic        capture;
    logic        retire;

    eirq_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin),
        .fall  (fall)
    );

    assign capture = fall & type_q;
    assign retire  = ack_valid && (ack_vector == VADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= 1'b0;
        end else if (wr_en) begin
            type_q <= wr_type;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = wr_flag ? CH_PENDING : CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (capture) state_d = CH_PENDING;
                end
                CH_PENDING: begin
                    if (retire && !capture) state_d = CH_IDLE;
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        type_o = type_q;
        flag_o = (state_q == CH_PENDING);
        req_o  = type_q ? flag_o : ~pin;
    end

endmodule

// File: rtl/eirq_detector.sv
`timescale 1ns/1ps
module eirq_detector
    import eirq_pkg::*;
#(
    parameter int N_SRC      = 2,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 16,
    localparam int REG_W     = 2 * N_SRC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       pin_i,
    input  logic                   reg_wr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic                   ack_valid,
    input  logic [VEC_W-1:0]       ack_vector,
    output logic [N_SRC-1:0]       irq_req,
    output logic [N_SRC*VEC_W-1:0] irq_vec
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam logic [VEC_W-1:0] VADDR = VEC_W'(vec_addr(VEC_BASE, VEC_STRIDE, i));
        logic type_b;
        logic flag_b;

        eirq_chan #(
            .VEC_W (VEC_W),
            .VADDR (VADDR)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_i[i]),
            .wr_en      (reg_wr),
            .wr_type    (reg_wdata[2*i]),
            .wr_flag    (reg_wdata[2*i+1]),
            .ack_valid  (ack_valid),
            .ack_vector (ack_vector),
            .type_o     (type_b),
            .flag_o     (flag_b),
            .req_o      (irq_req[i])
        );

        assign reg_rdata[2*i]            = type_b;
        assign reg_rdata[2*i+1]          = flag_b;
        assign irq_vec[i*VEC_W +: VEC_W] = VADDR;
    end

endmodule

// File: rtl/eirq_detector_chk.sv
`timescale 1ns/1ps
module eirq_detector_chk #(
    parameter int N_SRC      = 2,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 16,
    localparam int REG_W     = 2 * N_SRC
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_SRC-1:0]       pin_i,
    input logic                   reg_wr,
    input logic [REG_W-1:0]       reg_wdata,
    input logic [REG_W-1:0]       reg_rdata,
    input logic                   ack_valid,
    input logic [VEC_W-1:0]       ack_vector,
    input logic [N_SRC-1:0]       irq_req,
    input logic [N_SRC*VEC_W-1:0] irq_vec
);

    logic [N_SRC-1:0] pin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_d <= '1;
        else        pin_d <= pin_i;
    end

    a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == $past(reg_wdata));

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        localparam logic [VEC_W-1:0] VA = VEC_W'(VEC_BASE + i * VEC_STRIDE);

        a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_wr && reg_rdata[2*i] && pin_d[i] && !pin_i[i]) |=> reg_rdata[2*i+1]);

        a_r3_edge_req: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rdata[2*i] |-> (irq_req[i] == reg_rdata[2*i+1]));

        a_r4_level_req: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_rdata[2*i] |-> (irq_req[i] == !pin_i[i]));

        a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_vector == VA && !reg_wr &&
             !(reg_rdata[2*i] && pin_d[i] && !pin_i[i])) |=> !reg_rdata[2*i+1]);

        a_r6_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_vector == VA && !reg_wr &&
             reg_rdata[2*i] && pin_d[i] && !pin_i[i]) |=> reg_rdata[2*i+1]);
    end

endmodule

bind eirq_detector eirq_detector_chk #(
    .N_SRC      (N_SRC),
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec)
);

// File: tb/sim_eirq_detector.sv
`timescale 1ns/1ps
module sim_eirq_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin_i = 2'b11;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wdata = '0;
    logic [3:0]  reg_rdata;
    logic        ack_valid = 1'b0;
    logic [15:0] ack_vector = '0;
    logic [1:0]  irq_req;
    logic [31:0] irq_vec;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0] m_typ = 2'b00;
    logic [1:0] m_flg = 2'b00;
    logic [1:0] m_prev = 2'b11;

    always #4 clk = ~clk;

    eirq_detector u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ack_valid  (ack_valid),
        .ack_vector (ack_vector),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_nib();
        return {m_flg[1], m_typ[1], m_flg[0], m_typ[0]};
    endfunction

    function automatic logic [1:0] m_req();
        logic [1:0] r;
        for (int i = 0; i < 2; i++) r[i] = m_typ[i] ? m_flg[i] : ~pin_i[i];
        return r;
    endfunction

    // one clock edge: update model from present inputs, then compare
    task automatic tick();
        logic [1:0] nt, nf;
        for (int i = 0; i < 2; i++) begin
            logic fall, hit;
            fall = m_prev[i] & ~pin_i[i];
            hit  = ack_valid && (ack_vector == 16'h0003 + 16'(i * 16));
            nt[i] = m_typ[i];
            nf[i] = m_flg[i];
            if (reg_wr) begin
                nt[i] = reg_wdata[2*i];
                nf[i] = reg_wdata[2*i+1];
            end else if (fall && m_typ[i]) begin
                nf[i] = 1'b1;
            end else if (hit) begin
                nf[i] = 1'b0;
            end
        end
        m_typ  = nt;
        m_flg  = nf;
        m_prev = pin_i;
        @(posedge clk);
        @(negedge clk);
        check("R2 R5 R6 R7 model nibble", 32'(reg_rdata), 32'(m_nib()));
        check("R3 R4 model request", 32'(irq_req), 32'(m_req()));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset nibble", 32'(reg_rdata), 32'h0);
        check("R1 reset request", 32'(irq_req), 32'h0);
        check("R8 vector 0", 32'(irq_vec[15:0]), 32'h0003);
        check("R8 vector 1", 32'(irq_vec[31:16]), 32'h0013);

        // R2: write both sources to edge mode
        reg_wr = 1'b1; reg_wdata = 4'b0101; tick(); reg_wr = 1'b0;
        check("R2 write readback", 32'(reg_rdata), 32'h5);

        // R3: falling edge on source 0
        pin_i = 2'b10; tick();
        check("R3 edge flag", 32'(reg_rdata), 32'h7);
        check("R3 edge request", 32'(irq_req), 32'h1);

        // R9: acknowledge while input held low
        ack_valid = 1'b1; ack_vector = 16'h0003; tick(); ack_valid = 1'b0;
        check("R9 ack clears", 32'(reg_rdata), 32'h5);
        tick();
        check("R9 held low no reflag", 32'(reg_rdata), 32'h5);
        check("R9 request low", 32'(irq_req), 32'h0);

        // R6: new edge together with acknowledge
        pin_i = 2'b11; tick();
        pin_i = 2'b10; ack_valid = 1'b1; ack_vector = 16'h0003; tick(); ack_valid = 1'b0;
        check("R6 edge beats ack", 32'(reg_rdata), 32'h7);

        // R5: acknowledge selectivity
        reg_wr = 1'b1; reg_wdata = 4'b1111; tick(); reg_wr = 1'b0;
        ack_valid = 1'b1; ack_vector = 16'h0013; tick();
        check("R5 ack 0013h clears flag 1 only", 32'(reg_rdata), 32'h7);
        ack_vector = 16'h000B; tick();
        check("R5 foreign vector ignored", 32'(reg_rdata), 32'h7);
        ack_valid = 1'b0; ack_vector = 16'h0003; tick();
        check("R5 strobe low ignored", 32'(reg_rdata), 32'h7);

        // R7: write beats edge
        pin_i = 2'b11; tick();
        pin_i = 2'b10; reg_wr = 1'b1; reg_wdata = 4'b0101; tick(); reg_wr = 1'b0;
        check("R7 write beats edge", 32'(reg_rdata), 32'h5);

        // R4: level mode
        reg_wr = 1'b1; reg_wdata = 4'b0000; tick(); reg_wr = 1'b0;
        check("R4 level request follows pin", 32'(irq_req), 32'h1);
        pin_i = 2'b11; #1;
        check("R4 level request released", 32'(irq_req), 32'h0);
        pin_i = 2'b01; #1;
        check("R4 level request source 1", 32'(irq_req), 32'h2);
        tick();
        check("R4 no latch in level mode", 32'(reg_rdata), 32'h0);

        // exhaustive sweep
        for (int wd = 0; wd < 16; wd++) begin
            for (int w = 0; w < 2; w++) begin
                for (int ak = 0; ak < 4; ak++) begin
                    for (int p = 0; p < 4; p++) begin
                        reg_wr     = (w == 1) && (p == 0);
                        reg_wdata  = 4'(wd);
                        ack_valid  = (ak != 0);
                        ack_vector = (ak == 1) ? 16'h0003 : (ak == 2) ? 16'h0013 : 16'h000B;
                        pin_i      = 2'(p ^ ak);
                        tick();
                    end
                end
            end
        end
        reg_wr = 1'b0; ack_valid = 1'b0;
        check("R8 vectors after sweep", irq_vec, 32'h0013_0003);
        summary();
    end

endmodule